// File: doc/BRIEF.md
# Interrupt Source Crossbar Router

The router connects a large set of peripheral interrupt sources to a smaller set of interrupt-controller input lines. Each output line owns a routing register that holds the index of the source driven onto that line. The selected source level reaches the output through combinational logic only, with no latching. A software agent can read and write the routing registers over a simple register bus. Register `k` sits at byte address `k * REG_BYTES`.

Two parameter masks give certain lines special treatment. A reserved line has no routing. It drives a fixed direct input instead, and its register stays at the safe selection value whatever is written to it. A skipped line keeps a working register that can be written and read back, but the line is hard-wired around the router and also drives its direct input. On reset every register loads the safe selection value, which is 0 by default, so unused lines are parked on a known source.

Top module: `irq_xbar`

## Requirements
- R1: After reset every routing register reads back the value SAFE_SEL (default 0).
- R2: A routed line `irq_o[k]` equals `src_i[n]` in the same cycle, where `n` is the value held in register k and `n < NUM_SRC`.
- R3: A routed line whose register holds a value of `NUM_SRC` or more drives 0.
- R4: When `req_i` and `we_i` are high on a clock edge and `addr_i` is a multiple of REG_BYTES below `NUM_OUT*REG_BYTES`, register `addr_i/REG_BYTES` takes `wdata_i`. A read (`req_i` high, `we_i` low) places that register on `rdata_o` after the edge. `rdata_o` holds its value between reads.
- R5: A line whose bit is set in RSV_MASK drives `direct_i[k]`. Writes to its register are ignored and a read returns SAFE_SEL. By default, lines 0 to 3 are reserved.
- R6: A line whose bit is set in SKIP_MASK drives `direct_i[k]`. Its register still accepts writes and reads them back, and those writes do not change the output. By default, line 10 is skipped.
- R7: An access at an address that is not a multiple of REG_BYTES, or that is at or above `NUM_OUT*REG_BYTES`, changes no register. A read at such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_SRC | Level interrupt sources |
| direct_i | input | NUM_OUT | Fixed inputs for reserved and skipped lines |
| irq_o | output | NUM_OUT | Lines to the interrupt controller |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Write enable (1 = write, 0 = read) |
| addr_i | input | clog2(NUM_OUT*REG_BYTES) | Byte address |
| wdata_i | input | 8*REG_BYTES | Write data |
| rdata_o | output | 8*REG_BYTES | Read data, registered |

## Verification
The assertions assume that the bus controls are at known levels while out of reset. They also assume that `wdata_i` is stable at the same edge that samples `req_i`. The bench drives every input on the falling edge, which keeps both assumptions true. Random register writes use index values across the whole 9-bit range, so some land at or above the source count. Directed accesses then hit reserved lines, skipped lines, misaligned addresses and addresses past the register file. The random source and direct vectors are redrawn between the output checks.

// File: rtl/irq_xbar_pkg.sv
package irq_xbar_pkg;
  typedef enum logic [1:0] {
    LINE_ROUTED   = 2'd0,
    LINE_RESERVED = 2'd1,
    LINE_SKIPPED  = 2'd2
  } line_kind_e;

  // reserved wins over skipped when both masks set a bit
  function automatic line_kind_e line_kind(input logic rsv, input logic skp);
    if (rsv) return LINE_RESERVED;
    if (skp) return LINE_SKIPPED;
    return LINE_ROUTED;
  endfunction
endpackage

// File: rtl/irq_xbar_regs.sv
module irq_xbar_regs #(
  parameter int unsigned NUM_OUT   = 160,
  parameter int unsigned REG_BYTES = 2,
  parameter int unsigned SAFE_SEL  = 0,
  parameter logic [NUM_OUT-1:0] RSV_MASK = '0,
  localparam int unsigned DATA_W = 8 * REG_BYTES,
  localparam int unsigned ADDR_W = $clog2(NUM_OUT * REG_BYTES),
  localparam int unsigned OFF_W  = $clog2(REG_BYTES),
  localparam int unsigned OUT_W  = $clog2(NUM_OUT)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            req_i,
  input  logic                            we_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [DATA_W-1:0]               wdata_i,
  output logic [DATA_W-1:0]               rdata_o,
  output logic [NUM_OUT-1:0][DATA_W-1:0]  sel_o
);
  localparam logic [DATA_W-1:0] SAFE = DATA_W'(SAFE_SEL);
  localparam logic [ADDR_W:0]   LIMIT = (ADDR_W+1)'(NUM_OUT * REG_BYTES);

  logic             aligned, in_range, hit;
  logic [ADDR_W-1:0] word_idx;
  logic [OUT_W-1:0]  idx;

  assign aligned  = (addr_i & ADDR_W'(REG_BYTES - 1)) == '0;
  assign in_range = {1'b0, addr_i} < LIMIT;
  assign hit      = aligned && in_range;
  assign word_idx = addr_i >> OFF_W;
  assign idx      = OUT_W'(word_idx);

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_reg
    if (RSV_MASK[k]) begin : g_rsv
      assign sel_o[k] = SAFE;
    end else begin : g_rw
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                   q <= SAFE;
        else if (req_i && we_i && hit && idx == OUT_W'(k)) q <= wdata_i;
      end
      assign sel_o[k] = q;

      p_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && we_i && hit && idx == OUT_W'(k)) |=> sel_o[k] == $past(wdata_i));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rdata_o <= '0;
    else if (req_i && !we_i)  rdata_o <= hit ? sel_o[idx] : '0;
  end

  p_bad_addr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !hit) |=> rdata_o == '0);
endmodule

// File: rtl/irq_xbar_route.sv
module irq_xbar_route
  import irq_xbar_pkg::*;
#(
  parameter int unsigned NUM_SRC   = 400,
  parameter int unsigned NUM_OUT   = 160,
  parameter int unsigned DATA_W    = 16,
  parameter logic [NUM_OUT-1:0] RSV_MASK  = '0,
  parameter logic [NUM_OUT-1:0] SKIP_MASK = '0,
  localparam int unsigned SRC_W = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]              src_i,
  input  logic [NUM_OUT-1:0]              direct_i,
  input  logic [NUM_OUT-1:0][DATA_W-1:0]  sel_i,
  output logic [NUM_OUT-1:0]              irq_o
);
  localparam logic [DATA_W-1:0] SRC_LIM = DATA_W'(NUM_SRC);

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_line
    localparam line_kind_e KIND = line_kind(RSV_MASK[k], SKIP_MASK[k]);
    if (KIND == LINE_ROUTED) begin : g_mux
      logic [SRC_W-1:0] s;
      assign s        = SRC_W'(sel_i[k]);
      assign irq_o[k] = (sel_i[k] < SRC_LIM) ? src_i[s] : 1'b0;
    end else begin : g_direct
      assign irq_o[k] = direct_i[k];
    end
  end
endmodule

// File: rtl/irq_xbar.sv
module irq_xbar #(
  parameter int unsigned NUM_SRC   = 400,
  parameter int unsigned NUM_OUT   = 160,
  parameter int unsigned REG_BYTES = 2,
  parameter int unsigned SAFE_SEL  = 0,
  parameter logic [NUM_OUT-1:0] RSV_MASK  = NUM_OUT'(32'h0000_000F),
  parameter logic [NUM_OUT-1:0] SKIP_MASK = NUM_OUT'(32'h0000_0400),
  localparam int unsigned DATA_W = 8 * REG_BYTES,
  localparam int unsigned ADDR_W = $clog2(NUM_OUT * REG_BYTES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_OUT-1:0] direct_i,
  output logic [NUM_OUT-1:0] irq_o,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o
);
  logic [NUM_OUT-1:0][DATA_W-1:0] sel;

  irq_xbar_regs #(
    .NUM_OUT(NUM_OUT), .REG_BYTES(REG_BYTES), .SAFE_SEL(SAFE_SEL), .RSV_MASK(RSV_MASK)
  ) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o, .sel_o(sel)
  );

  irq_xbar_route #(
    .NUM_SRC(NUM_SRC), .NUM_OUT(NUM_OUT), .DATA_W(DATA_W),
    .RSV_MASK(RSV_MASK), .SKIP_MASK(SKIP_MASK)
  ) u_route (
    .src_i, .direct_i, .sel_i(sel), .irq_o
  );

  localparam logic [NUM_OUT-1:0] BYPASS = RSV_MASK | SKIP_MASK;

  // R5/R6: bypassed lines follow direct_i regardless of register contents
  p_bypass_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & BYPASS) == (direct_i & BYPASS));

  // R3: register value past the source range keeps a routed line low
  for (genvar k = 0; k < NUM_OUT; k++) begin : g_chk
    if (!BYPASS[k]) begin : g_rt
      p_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel[k] >= DATA_W'(NUM_SRC)) |-> !irq_o[k]);
    end
  end

  // R1: line registers come out of reset at the safe selection
  p_reset_r1: assert property (@(posedge clk_i)
    !rst_ni |=> sel[NUM_OUT-1] == DATA_W'(SAFE_SEL));
endmodule

// File: tb/irq_xbar_tb.sv
module irq_xbar_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 400, NO = 160, RB = 2, DW = 16, AW = 9;
  localparam logic [NO-1:0] RSV  = NO'(32'h0000_000F);
  localparam logic [NO-1:0] SKIP = NO'(32'h0000_0400);

  logic clk = 0, rst_n = 0;
  logic [NS-1:0] src = '0;
  logic [NO-1:0] dir = '0, irq;
  logic req = 0, we = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata;

  int total = 0, fails = 0;
  int unsigned exp_reg [NO];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_xbar u_dut (.clk_i(clk), .rst_ni(rst_n), .src_i(src), .direct_i(dir),
    .irq_o(irq), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata));

  function automatic logic [NO-1:0] exp_irq();
    logic [NO-1:0] e;
    for (int k = 0; k < NO; k++)
      if (RSV[k] || SKIP[k]) e[k] = dir[k];
      else e[k] = (exp_reg[k] < NS) ? src[exp_reg[k]] : 1'b0;
    return e;
  endfunction

  function automatic logic [DW-1:0] exp_read(input int unsigned a);
    if (a % RB != 0 || a >= NO*RB) return '0;
    if (RSV[a/RB]) return '0;
    return DW'(exp_reg[a/RB]);
  endfunction

  task automatic check(input string req_tag, input logic [NO-1:0] act, input logic [NO-1:0] ex);
    total++;
    if (act !== ex) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req_tag, act, ex);
    end
  endtask

  task automatic bus_wr(input int unsigned a, input logic [DW-1:0] d);
    @(negedge clk); req = 1; we = 1; addr = AW'(a); wdata = d;
    @(negedge clk); req = 0; we = 0;
    if (a % RB == 0 && a < NO*RB && !RSV[a/RB]) exp_reg[a/RB] = d;
  endtask

  task automatic bus_rd_chk(input string req_tag, input int unsigned a);
    @(negedge clk); req = 1; we = 0; addr = AW'(a);
    @(negedge clk); req = 0;
    check(req_tag, NO'(rdata), NO'(exp_read(a)));
  endtask

  task automatic rand_inputs();
    for (int i = 0; i < NS; i++) src[i] = 1'($urandom);
    for (int i = 0; i < NO; i++) dir[i] = 1'($urandom);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd5417));
    for (int k = 0; k < NO; k++) exp_reg[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset values, including a reserved line
    bus_rd_chk("R1", 0);
    bus_rd_chk("R1", 2*57);
    bus_rd_chk("R1", 2*(NO-1));
    rand_inputs(); #1;
    check("R1 safe routing", irq, exp_irq());

    // R2 directed: line 20 -> source 399, line 21 -> source 0
    bus_wr(40, 16'd399); bus_wr(42, 16'd0);
    src = '0; src[399] = 1; #1;
    check("R2 top src", NO'(irq[20]), NO'(1'b1));
    check("R2 src0 low", NO'(irq[21]), NO'(1'b0));
    // R3: index at and beyond source count
    bus_wr(40, 16'd400); bus_wr(44, 16'hFFFF);
    src = '1; #1;
    check("R3 out of range", NO'({irq[22], irq[20]}), NO'(2'b00));
    bus_rd_chk("R4 readback ffff", 44);

    // R5: reserved line 2 ignores write, follows direct_i
    bus_wr(4, 16'd7);
    bus_rd_chk("R5 reserved read", 4);
    dir = '0; src = '1; #1;
    check("R5 reserved out", NO'(irq[3:0]), NO'(4'h0));
    dir[2] = 1; #1;
    check("R5 reserved direct", NO'(irq[2]), NO'(1'b1));

    // R6: skipped line 10 stores value but output stays direct
    bus_wr(20, 16'd33);
    bus_rd_chk("R6 skip readback", 20);
    src = '0; src[33] = 1; dir[10] = 0; #1;
    check("R6 skip bypass", NO'(irq[10]), NO'(1'b0));

    // R7: misaligned and out of range
    bus_wr(41, 16'd5);
    bus_wr(NO*RB, 16'd5);
    bus_wr(511, 16'd5);
    bus_rd_chk("R7 misaligned", 41);
    bus_rd_chk("R7 past end", NO*RB);
    bus_rd_chk("R7 past end", 511);
    bus_rd_chk("R7 neighbour intact", 40);

    // R4 + R2: random programming
    for (int it = 0; it < 40; it++) begin
      for (int w = 0; w < 12; w++) begin
        int unsigned a;
        a = (w % 6 == 0) ? ($urandom % 512) : 2 * ($urandom % NO);
        bus_wr(a, DW'($urandom % 512));
      end
      for (int r = 0; r < 3; r++) bus_rd_chk("R4 random read", 2 * ($urandom % NO));
      for (int v = 0; v < 4; v++) begin
        @(negedge clk); rand_inputs(); #1;
        check("R2 random route", irq, exp_irq());
      end
    end

    // R1: reset again restores safe selection
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    for (int k = 0; k < NO; k++) exp_reg[k] = 0;
    bus_rd_chk("R1 after reset", 2*50);
    rand_inputs(); #1;
    check("R1 after reset route", irq, exp_irq());

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule